// File: doc/BRIEF.md
# Equalizer Boost and Power-State Controller

This block decides the equalizer boost code and the power state of a video redriver with three data lanes and one clock lane. The boost code for the data lanes comes from one of two sources. A force input selects a shared 3-bit code taken from pins, which all three data lanes then use. Otherwise each data lane uses its own 3-bit field held in configuration registers. Code 000 is the weakest boost and 111 the strongest, which gives eight levels.

The device state is ACTIVE or STANDBY. A select bit in the registers picks who decides it. When the bit is clear, the enable pin decides. When it is set, a register bit decides and the enable pin has no effect. Each lane also has an internal disable bit. A lane's enable output is high only when the device is ACTIVE and that lane's disable bit is 0. In STANDBY every lane enable is low. A 2-bit output-amplitude code is copied to all four lanes.

The force, enable and boost pins are asynchronous. Each passes through a two-flop synchronizer. Every output is registered. The configuration register file sits outside this block and drives the `lane_cfg`, `state_src` and `amp_code` inputs.

Top module: `eq_boost_ctrl`

## Requirements
- R1: While the synchronized force input is 1, `boost_out` carries the synchronized pin code in all three lane slots. Data lane i occupies bits [3i+2:3i], and 000 is the minimum boost.
- R2: While the synchronized force input is 0, each lane uses its own register field. Data lane 0 takes `lane_cfg[6:4]`, data lane 1 takes `lane_cfg[10:8]` and data lane 2 takes `lane_cfg[14:12]`.
- R3: While `state_src` is 0, `active` follows the synchronized enable pin. A high pin gives ACTIVE (1) and a low pin gives STANDBY (0).
- R4: While `state_src` is 1, `active` is the inverse of `lane_cfg[3]`, so 0 gives ACTIVE. The enable pin has no effect on the state.
- R5: In ACTIVE, `lane_en[k]` is the inverse of that lane's disable bit. Bit 0 is the clock lane, whose disable bit is `lane_cfg[3]`. Bits 1, 2 and 3 are data lanes 0, 1 and 2, whose disable bits are `lane_cfg[7]`, `lane_cfg[11]` and `lane_cfg[15]`.
- R6: In STANDBY (`active` = 0), all four lane enables are 0.
- R7: `amp_out` holds `amp_code` in each of its four 2-bit lane slots. Lane k occupies bits [2k+1:2k].
- R8: A change on a pin input reaches the outputs on the third rising clock edge after it. A change on a register input reaches the outputs on the next rising edge.
- R9: While `rst` is high, the outputs hold these values: `boost_out` is 0, `lane_en` is 0, `active` is 0, and every `amp_out` slot is 10. The synchronizers clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| force_pin | input | 1 | Asynchronous. 1 selects the shared pin boost code |
| en_pin | input | 1 | Asynchronous enable pin level |
| boost_pin | input | 3 | Asynchronous shared boost code |
| lane_cfg | input | 13 (bits 15:3) | Per-lane disable bits and boost fields from the register file |
| state_src | input | 1 | 1 lets the register bit set the state; 0 lets the enable pin set it |
| amp_code | input | 2 | Output-amplitude code |
| boost_out | output | 9 | Per-data-lane boost codes, 3 bits each |
| lane_en | output | 4 | Lane enables. Bit 0 is the clock lane; bits 1 to 3 are data lanes 0 to 2 |
| active | output | 1 | 1 = ACTIVE, 0 = STANDBY |
| amp_out | output | 8 | Per-lane amplitude code, 2 bits each |

## Verification
The case hardest to reach is a pin change and a register change that arrive close together. The register change shows up one edge after it is applied. The pin change shows up three edges after it is applied. For a short window the outputs therefore mix new register data with old pin data. Examples are a force-mode switch that lands while the lane fields are moving, and a change of state source while the enable pin is toggling.

The bench uses a free-running pseudo-random sequence to change pins and registers on the same cycles. A reference model of the differing delays compares the outputs on every clock. A directed step confirms that a pin change arrives exactly on the third edge.

// File: rtl/eqc_pkg.sv
package eqc_pkg;
  localparam int NUM_DATA  = 3;
  localparam int NUM_LANES = NUM_DATA + 1;
  localparam int BOOST_W   = 3;
  localparam int AMP_W     = 2;
  localparam int CFG_HI    = 4 * NUM_LANES - 1;
  localparam int SYNC_W    = BOOST_W + 2;
  localparam int IDX_EN    = BOOST_W;
  localparam int IDX_FORCE = BOOST_W + 1;
  localparam logic [AMP_W-1:0] AMP_RST = 2'b10;

  // Nibble k of the lane configuration word:
  // bit 3 is the disable bit, bits 2:0 are the boost field (data lanes only).
  function automatic int dis_bit(input int k);
    return 4 * k + 3;
  endfunction

  function automatic int boost_lsb(input int data_lane);
    return 4 * (data_lane + 1);
  endfunction
endpackage

// File: rtl/eqc_sync.sv
module eqc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/eqc_boost_sel.sv
module eqc_boost_sel
  import eqc_pkg::*;
(
  input  logic                        force_ext,
  input  logic [BOOST_W-1:0]          pin_code,
  input  logic [CFG_HI:3]             lane_cfg,
  output logic [BOOST_W*NUM_DATA-1:0] lane_code
);
  for (genvar i = 0; i < NUM_DATA; i++) begin : g_lane
    localparam int LSB = boost_lsb(i);
    always_comb begin
      if (force_ext) lane_code[BOOST_W*i +: BOOST_W] = pin_code;
      else           lane_code[BOOST_W*i +: BOOST_W] = lane_cfg[LSB +: BOOST_W];
    end
  end
endmodule

// File: rtl/eqc_power.sv
module eqc_power
  import eqc_pkg::*;
(
  input  logic                 en_level,
  input  logic                 state_src,
  input  logic [CFG_HI:3]      lane_cfg,
  output logic                 active,
  output logic [NUM_LANES-1:0] lane_en
);
  typedef enum logic {ST_STANDBY = 1'b0, ST_ACTIVE = 1'b1} pstate_t;
  pstate_t st;

  always_comb begin
    if (state_src) st = lane_cfg[dis_bit(0)] ? ST_STANDBY : ST_ACTIVE;
    else           st = en_level ? ST_ACTIVE : ST_STANDBY;
  end

  assign active = (st == ST_ACTIVE);

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_en
    assign lane_en[k] = active & ~lane_cfg[dis_bit(k)];
  end
endmodule

// File: rtl/eq_boost_ctrl.sv
module eq_boost_ctrl
  import eqc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        force_pin,
  input  logic                        en_pin,
  input  logic [BOOST_W-1:0]          boost_pin,
  input  logic [CFG_HI:3]             lane_cfg,
  input  logic                        state_src,
  input  logic [AMP_W-1:0]            amp_code,
  output logic [BOOST_W*NUM_DATA-1:0] boost_out,
  output logic [NUM_LANES-1:0]        lane_en,
  output logic                        active,
  output logic [AMP_W*NUM_LANES-1:0]  amp_out
);
  logic [SYNC_W-1:0]           pin_raw;
  logic [SYNC_W-1:0]           pin_s;
  logic [BOOST_W*NUM_DATA-1:0] boost_nxt;
  logic                        active_nxt;
  logic [NUM_LANES-1:0]        en_nxt;

  assign pin_raw = {force_pin, en_pin, boost_pin};

  eqc_sync #(.W(SYNC_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (pin_s)
  );

  eqc_boost_sel u_bsel (
    .force_ext (pin_s[IDX_FORCE]),
    .pin_code  (pin_s[BOOST_W-1:0]),
    .lane_cfg  (lane_cfg),
    .lane_code (boost_nxt)
  );

  eqc_power u_pwr (
    .en_level  (pin_s[IDX_EN]),
    .state_src (state_src),
    .lane_cfg  (lane_cfg),
    .active    (active_nxt),
    .lane_en   (en_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      boost_out <= '0;
      lane_en   <= '0;
      active    <= 1'b0;
      amp_out   <= {NUM_LANES{AMP_RST}};
    end else begin
      boost_out <= boost_nxt;
      lane_en   <= en_nxt;
      active    <= active_nxt;
      amp_out   <= {NUM_LANES{amp_code}};
    end
  end
endmodule

// File: rtl/eqc_checker.sv
module eqc_checker
  import eqc_pkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic                        force_pin,
  input logic                        en_pin,
  input logic [BOOST_W-1:0]          boost_pin,
  input logic [CFG_HI:3]             lane_cfg,
  input logic                        state_src,
  input logic [AMP_W-1:0]            amp_code,
  input logic [BOOST_W*NUM_DATA-1:0] boost_out,
  input logic [NUM_LANES-1:0]        lane_en,
  input logic                        active,
  input logic [AMP_W*NUM_LANES-1:0]  amp_out
);
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  a_r1_pin_boost_shared: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && $past(force_pin, 3)) |->
      (boost_out[2:0] == $past(boost_pin, 3) && boost_out[5:3] == $past(boost_pin, 3)
       && boost_out[8:6] == $past(boost_pin, 3)));

  a_r2_reg_boost_lanes: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && !$past(force_pin, 3)) |->
      (boost_out[2:0] == $past(lane_cfg[6:4]) && boost_out[5:3] == $past(lane_cfg[10:8])
       && boost_out[8:6] == $past(lane_cfg[14:12])));

  a_r3_pin_state: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && !$past(state_src)) |-> (active == $past(en_pin, 3)));

  a_r4_reg_state: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1 && $past(state_src)) |-> (active == !$past(lane_cfg[3])));

  a_r5_lane_mask: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1 && active) |->
      (lane_en == ~{$past(lane_cfg[15]), $past(lane_cfg[11]), $past(lane_cfg[7]), $past(lane_cfg[3])}));

  a_r6_standby_off: assert property (@(posedge clk) disable iff (rst)
    !active |-> (lane_en == '0));

  a_r7_amp_copy: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1) |-> (amp_out == {NUM_LANES{$past(amp_code)}}));

  a_r9_reset_values: assert property (@(posedge clk)
    rst |=> (!active && lane_en == '0 && boost_out == '0 && amp_out == {NUM_LANES{AMP_RST}}));
endmodule

bind eq_boost_ctrl eqc_checker u_chk (.*);

// File: tb/sim_eq_boost_ctrl.sv
module sim_eq_boost_ctrl;
  localparam time TCLK = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        force_pin = 1'b0;
  logic        en_pin = 1'b0;
  logic [2:0]  boost_pin = 3'd0;
  logic [7:0]  r3 = 8'h77;
  logic [7:0]  r4 = 8'h77;
  logic [15:3] lane_cfg;
  logic        state_src = 1'b0;
  logic [1:0]  amp_code = 2'b10;
  logic [8:0]  boost_out;
  logic [3:0]  lane_en;
  logic        active;
  logic [7:0]  amp_out;

  assign lane_cfg = {r4, r3[7:3]};

  eq_boost_ctrl u0 (
    .clk(clk), .rst(rst), .force_pin(force_pin), .en_pin(en_pin),
    .boost_pin(boost_pin), .lane_cfg(lane_cfg), .state_src(state_src),
    .amp_code(amp_code), .boost_out(boost_out), .lane_en(lane_en),
    .active(active), .amp_out(amp_out)
  );

  always #(TCLK/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: pins take three edges, registers one
  logic [4:0] pin_q[$];
  logic [8:0] e_boost;
  logic [3:0] e_en;
  logic       e_act;
  logic [7:0] e_amp;
  bit         e_force;

  always @(posedge clk) begin
    logic [4:0] old;
    if (rst) begin
      pin_q.delete();
      e_boost = '0; e_en = '0; e_act = 1'b0; e_amp = 8'hAA; e_force = 1'b0;
    end else begin
      pin_q.push_back({force_pin, en_pin, boost_pin});
      if (pin_q.size() > 2) old = pin_q.pop_front();
      else old = 5'd0;
      e_force = old[4];
      if (old[4]) e_boost = {old[2:0], old[2:0], old[2:0]};
      else        e_boost = {r4[6:4], r4[2:0], r3[6:4]};
      e_act = state_src ? !r3[3] : old[3];
      e_en  = e_act ? ~{r4[7], r4[3], r3[7], r3[3]} : 4'b0;
      e_amp = {4{amp_code}};
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk(e_force ? "R1" : "R2", boost_out, e_boost);
      chk(state_src ? "R4" : "R3", active, e_act);
      chk(e_act ? "R5" : "R6", lane_en, e_en);
      chk("R7", amp_out, e_amp);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_check();
    rst = 1'b1;
    cyc(3);
    chk("R9 boost", boost_out, 0);
    chk("R9 en", lane_en, 0);
    chk("R9 active", active, 0);
    chk("R9 amp", amp_out, 8'hAA);
    rst = 1'b0;
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", wd);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    reset_check();
    model_on = 1'b1;
    // pin-driven shared boost, pin-driven state
    en_pin = 1'b1; force_pin = 1'b1; boost_pin = 3'd3;
    cyc(6);
    // R8 latency: pin step 3 -> 6 lands on the third edge
    boost_pin = 3'd6;
    cyc(2);
    chk("R8 two edges", boost_out, {3'd3, 3'd3, 3'd3});
    cyc(1);
    chk("R8 third edge", boost_out, {3'd6, 3'd6, 3'd6});
    // R8 register path: one edge
    force_pin = 1'b0; cyc(5);
    r3 = 8'h20; r4 = 8'h51;
    cyc(1);
    chk("R8 reg edge", boost_out, {3'd5, 3'd1, 3'd2});
    // per-lane disable patterns in ACTIVE
    r3 = 8'h88; cyc(2);
    r4 = 8'h08; cyc(2);
    r4 = 8'h80; r3 = 8'h00; cyc(2);
    // STANDBY via pin
    en_pin = 1'b0; cyc(5);
    chk("R6 standby pin", lane_en, 0);
    // register-owned state: pin ignored
    state_src = 1'b1; r3 = 8'h00; cyc(2);
    en_pin = 1'b1; cyc(4);
    en_pin = 1'b0; cyc(4);
    chk("R4 pin ignored", active, 1);
    r3 = 8'h08; cyc(2);
    chk("R4 reg standby", active, 0);
    state_src = 1'b0; cyc(3);
    // amplitude codes
    for (int a = 0; a < 4; a++) begin amp_code = a[1:0]; cyc(2); end
    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      force_pin = lfsr[0]; en_pin = lfsr[1] | lfsr[9];
      boost_pin = lfsr[4:2];
      if (lfsr[5]) r3 = lfsr[15:8];
      if (lfsr[6]) r4 = lfsr[12:5];
      if (lfsr[7] & lfsr[11]) state_src = ~state_src;
      amp_code = lfsr[14:13];
      cyc(1);
    end
    // reset in mid-run
    model_on = 1'b0;
    reset_check();
    model_on = 1'b1;
    cyc(10);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule